// File: doc/BRIEF.md
# Serial Bitstream Word Packer

This block sits behind a 1-bit modulator. It gathers the modulator's output bits into words and sends them out on a serial data line as a clock-follower transmitter. Bits arrive one per valid/ready handshake on the producer side. Each completed word moves into a transmit holding register as soon as that register is free. The holding register then shifts the word out under a serial clock that comes from outside, for example from a timer. The serial clock is not related to the system clock. It is synchronised into the system domain, and only its falling edges are used.

Back-pressure rules on the producer side are as follows. `bit_ready` is high whenever the packer has room. It drops once a full word is waiting and the holding register is still busy. While `bit_ready` is low, `bit_valid` and `bit_data` are ignored, and the producer must hold its bit until the handshake completes. A bit is consumed on a rising `clk` edge where both `bit_valid` and `bit_ready` are high. The serial side applies no back-pressure. The external clock master must wait for `tx_empty` to go low before it clocks a word, and must give exactly as many falling edges as there are bits in a word.

Top module: `bitpack_spi_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, `tx_empty` is 1, `bit_ready` is 1 and `sdo` is 0. Asserting reset in the middle of a transmission returns the outputs to these values.
- R2: The k-th accepted bit of a word (k counted from 0) lands in word bit k. Every word starts from all zeros, so a bit position holds 1 only if the bit accepted for it was 1.
- R3: A completed word moves to the holding register only while `tx_empty` is 1. While a completed word waits, `bit_ready` is 0 and any offered bits are ignored. No bit is lost or taken twice.
- R4: When a word is loaded, `tx_empty` falls and `sdo` presents word bit 0 before any serial clock edge.
- R5: Each falling edge of `sclk` while busy advances `sdo` to the next word bit, in the order bit 0, bit 1, up to the top bit. `sdo` settles within 4 system clocks of the edge, so the far end can sample on the next rising edge of `sclk`.
- R6: The falling edge that consumes the last bit sets `tx_empty` to 1 without shifting. While empty, `sdo` keeps the last bit and further `sclk` edges have no effect.
- R7: Across consecutive words, the serial line repeats the accepted bit sequence in time order. Each `sclk` phase must last at least SYNC_STAGES+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Producer offers a modulator bit |
| bit_data | input | 1 | Modulator bit value |
| bit_ready | output | 1 | Packer can take a bit this cycle |
| sclk | input | 1 | External serial clock, asynchronous to `clk`, idles low |
| sdo | output | 1 | Serial data out, changes after `sclk` falling edges |
| tx_empty | output | 1 | Holding register has no word in flight |

## Verification
The bench builds the block with its default 8-bit word and a 2-flop synchroniser. An 8-bit word makes all-zero, all-one, single-bit and alternating patterns small enough to list by hand. The bench drives the serial clock with a 66 ns phase, which has no fixed relation to the 10 ns system clock. This exercises the synchroniser's margin against the R7 minimum phase length, and it lets a full word queue up behind a busy holding register so that back-pressure can be seen.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  // Default word length and synchroniser depth shared by the block and its bench.
  localparam int unsigned BSP_WORD_W_DEF = 8;
  localparam int unsigned BSP_SYNC_DEF   = 2;
endpackage

// File: rtl/bsp_sclk_sync.sv
module bsp_sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_async,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sclk_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // One-cycle pulse on a high-to-low transition of the synchronised clock.
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/bsp_packer.sv
module bsp_packer #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_data,
  output logic              in_ready,
  output logic [WORD_W-1:0] word_o,
  output logic              word_full_o,
  input  logic              word_take
);
  localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;
  logic              accept;

  assign in_ready    = ~full_q;
  assign accept      = in_valid & ~full_q;
  assign word_o      = acc_q;
  assign word_full_o = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (word_take) begin
      // Word handed over: start the next one from zero.
      acc_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      if (in_data) acc_q[idx_q] <= 1'b1;
      if (idx_q == LAST_IDX) begin
        idx_q  <= '0;
        full_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsp_shifter.sv
module bsp_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_edge,
  output logic              sdo,
  output logic              empty_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  edges_q;
  logic              empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      edges_q <= '0;
      empty_q <= 1'b1;
    end else if (load) begin
      sh_q    <= load_word;
      edges_q <= '0;
      empty_q <= 1'b0;
    end else if (shift_edge && !empty_q) begin
      if (edges_q == LAST_EDGE) begin
        // Last bit consumed: keep it on the line and report empty.
        empty_q <= 1'b1;
      end else begin
        sh_q    <= sh_q >> 1;
        edges_q <= edges_q + 1'b1;
      end
    end
  end

  assign sdo     = sh_q[0];
  assign empty_o = empty_q;
endmodule

// File: rtl/bitpack_spi_tx.sv
module bitpack_spi_tx #(
  parameter int unsigned WORD_W      = bsp_pkg::BSP_WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = bsp_pkg::BSP_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  input  logic sclk,
  output logic sdo,
  output logic tx_empty
);
  logic [WORD_W-1:0] packed_word;
  logic              word_full;
  logic              word_load;
  logic              sclk_fall;

  generate
    if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  bsp_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_async (sclk),
    .fall_o     (sclk_fall)
  );

  bsp_packer #(.WORD_W(WORD_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (bit_valid),
    .in_data     (bit_data),
    .in_ready    (bit_ready),
    .word_o      (packed_word),
    .word_full_o (word_full),
    .word_take   (word_load)
  );

  // Hand a finished word over only when the holding register is free.
  assign word_load = word_full & tx_empty;

  bsp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (word_load),
    .load_word  (packed_word),
    .shift_edge (sclk_fall),
    .sdo        (sdo),
    .empty_o    (tx_empty)
  );
endmodule

// File: rtl/bitpack_spi_tx_chk.sv
module bitpack_spi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_empty,
  input logic sdo,
  input logic word_full,
  input logic word_load,
  input logic sclk_fall
);
  // R6: an idle holding register keeps the line steady.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> (!tx_empty || $stable(sdo)));

  // R5: the line moves only after a detected falling edge or a load.
  a_r5_sdo_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sclk_fall) || $past(word_load)));

  // R6: empty is reported only in answer to a falling edge.
  a_r6_empty_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(sclk_fall));

  // R3: the holding register fills only from a completed word.
  a_r3_load_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(word_full));

  // R3: a waiting word leaves only through a load.
  a_r3_word_waits: assert property (@(posedge clk) disable iff (!rst_n)
    word_full |=> (word_full || !tx_empty));
endmodule

bind bitpack_spi_tx bitpack_spi_tx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_empty  (tx_empty),
  .sdo       (sdo),
  .word_full (word_full),
  .word_load (word_load),
  .sclk_fall (sclk_fall)
);

// File: tb/bitpack_spi_tx_tb_top.sv
`timescale 1ns/1ps
module bitpack_spi_tx_tb_top;
  localparam int unsigned W = 8;
  localparam int unsigned NVEC = 10;
  localparam logic [W-1:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5,
                                          8'h5A, 8'h3C, 8'hC3, 8'h96, 8'h7E};
  localparam time HALF_SCLK = 66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic sclk = 1'b0;
  logic sdo;
  logic tx_empty;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bitpack_spi_tx #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_ready (bit_ready),
    .sclk      (sclk),
    .sdo       (sdo),
    .tx_empty  (tx_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    while (!bit_ready) @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) send_bit(w[i]);
  endtask

  // Acts as the serial clock master: waits for a word, samples on rising edges.
  task automatic master_word(output logic [W-1:0] got);
    @(negedge clk);
    while (tx_empty) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      #(HALF_SCLK) sclk = 1'b1;
      got[i] = sdo;
      #(HALF_SCLK) sclk = 1'b0;
    end
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] got;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 tx_empty in reset", tx_empty, 1);
    check("R1 bit_ready in reset", bit_ready, 1);
    check("R1 sdo in reset", sdo, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sdo idle after reset", sdo, 0);

    // R2 R5 R7: vector table streamed back to back
    fork
      begin
        for (int k = 0; k < NVEC; k++) send_word(VEC[k]);
      end
      begin
        for (int k = 0; k < NVEC; k++) begin
          master_word(got);
          check($sformatf("R2 R5 R7 word %0d order", k), got, VEC[k]);
        end
      end
    join

    // R4 R3: first bit driven at load, second word held back
    send_word(8'h6D);
    repeat (3) @(negedge clk);
    check("R4 tx_empty falls on load", tx_empty, 0);
    check("R4 bit 0 before any edge", sdo, 1);
    send_word(8'h92);
    repeat (2) @(negedge clk);
    check("R3 bit_ready low while word waits", bit_ready, 0);
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    begin
      logic seen_ready = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (bit_ready) seen_ready = 1'b1;
      end
      check("R3 stays stalled under offered bits", seen_ready, 0);
    end
    bit_valid = 1'b0;
    master_word(got);
    check("R5 first word out", got, 8'h6D);
    repeat (3) @(negedge clk);
    check("R3 waiting word loads when empty", tx_empty, 0);
    check("R4 waiting word bit 0 shown", sdo, 0);
    master_word(got);
    check("R3 waiting word intact", got, 8'h92);
    send_word(8'hCB);
    master_word(got);
    check("R3 offered bits were ignored", got, 8'hCB);

    // R6: idle hold and ignored edges
    check("R6 last bit held", sdo, 1);
    for (int i = 0; i < 2; i++) begin
      #(HALF_SCLK) sclk = 1'b1;
      #(HALF_SCLK) sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    check("R6 sdo unchanged by idle edges", sdo, 1);
    check("R6 stays empty", tx_empty, 1);

    // R1: reset in the middle of a word
    send_word(8'hF1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-word tx_empty", tx_empty, 1);
    check("R1 reset mid-word sdo", sdo, 0);
    check("R1 reset mid-word bit_ready", bit_ready, 1);

    done = 1'b1;
    finish_run();
  end
endmodule